// File: doc/BRIEF.md
# Burst-Access Synchronous SRAM Front End

This block models the synchronous front end of a burst static RAM. On each rising clock edge it decodes two active-low address strobes: a processor-side strobe and a controller-side strobe. It also decodes a burst-advance input, three chip enables and a set of write enables. From these it decides whether the edge loads a new burst, continues the current one, or deselects the device. A two-bit burst counter produces the low address bits of each beat, in either XOR-interleaved or wrapping-linear order. The advance input can hold the counter so that the same word is accessed again.

Writes go into a small parameterized byte-lane array, either as whole words or byte by byte. Reads leave through one register stage (flow-through) or two register stages (pipelined). An asynchronous output enable and the write-sampling rule gate the data output. The bidirectional data bus is split into a write-data input, a read-data output and an active-high drive-enable output.

Top module: `sbs_sram`

## Requirements
- R1: The processor strobe (`ads_proc_n` low) starts a burst only while `sel_main_n` is low. While `sel_main_n` is high the processor strobe is ignored, and the edge behaves as a continue edge of any burst in progress.
- R2: The controller strobe (`ads_ctrl_n` low) is taken when `ads_proc_n` is high or `sel_main_n` is high. With all chip enables active it loads `addr`. The write enables sampled on that same edge apply, so a write stores `wdata` on the load edge.
- R3: A burst started by the processor strobe is a read, whatever `gw_n`, `bwe_n`, `bw_n` and `ads_ctrl_n` are on that edge. Nothing is written on that edge.
- R4: `adv_n` is ignored on a load edge. On later edges with neither strobe taken, `adv_n` low steps the burst count by one. `adv_n` high repeats the access at the current address (suspend), for reads and writes alike.
- R5: The upper address bits of a burst stay at the loaded value. With `order_il` high, the low two bits are (start XOR count). With `order_il` low, they are (start + count) modulo 4.
- R6: `gw_n` low writes all bytes. Otherwise, `bwe_n` low writes byte i where `bw_n[i]` is low, and byte i is `wdata[8i+7:8i]`. With `bwe_n` high, or every `bw_n` bit high, the access is a read.
- R7: With `pipe_mode` high, a word read on edge k is presented between edges k+1 and k+2. With `pipe_mode` low, it is presented between edges k and k+1.
- R8: `rdata_en` is high only while `oe_n` is low and a valid read word is in the selected stage. An edge that performs a write invalidates both stages, so `rdata_en` is low after that edge regardless of `oe_n`. `rdata` is zero whenever `rdata_en` is low.
- R9: A taken strobe with `sel_pos` low or `sel_neg_n` high deselects the device, and so does a controller strobe with `sel_main_n` high. No access happens on that edge. A word already in the pipelined stage is still presented for its one remaining cycle.
- R10: While deselected, continue edges perform no access: write enables write nothing and no read data appears until a new burst is loaded.
- R11: A synchronous active-high `rst` clears the burst state and both read-valid flags, so `rdata_en` is low after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_main_n | input | 1 | Master chip enable, active low; gates the processor strobe |
| sel_pos | input | 1 | Chip enable, active high |
| sel_neg_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | BYTE_N | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| pipe_mode | input | 1 | Read path: 1 pipelined, 0 flow-through |
| addr | input | ADDR_W | Word address loaded by a strobe |
| wdata | input | 8*BYTE_N | Write data |
| rdata | output | 8*BYTE_N | Read data, zero when not driven |
| rdata_en | output | 1 | Read data drive enable |

## Verification
The assertions assume that all inputs are two-state and settle between edges. They also assume `ADDR_W` is at least 3, so that an upper address field exists beside the two burst bits. The suspend check further relies on an active burst having made an access on the previous edge, which only reset or a deselect can break.

The bench changes every input, including `order_il` and `pipe_mode`, only at falling edges. It switches the mode pins only between bursts, and fills every word of the array before the first read, so every compared read word is defined.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // What a rising edge does to the burst state.
    typedef enum logic [1:0] {
        OP_CONT  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_DESEL = 2'd2
    } sbs_op_e;

    // Low two address bits of a beat, from start bits and beat count.
    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       il);
        return il ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode #(
    parameter int BYTE_N = 4
) (
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              sel_main_n,
    input  logic              sel_pos,
    input  logic              sel_neg_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [BYTE_N-1:0] bw_n,
    output sbs_pkg::sbs_op_e  op,
    output logic              proc_load,
    output logic [BYTE_N-1:0] wr_mask
);
    import sbs_pkg::*;

    logic proc_take;
    logic ctrl_take;
    logic chip_on;
    logic [BYTE_N-1:0] raw_mask;

    always_comb begin
        // master enable gates the processor strobe only
        proc_take = !ads_proc_n && !sel_main_n;
        // controller strobe counts when the processor strobe is high or blocked
        ctrl_take = !ads_ctrl_n && (ads_proc_n || sel_main_n);
        chip_on   = !sel_main_n && sel_pos && !sel_neg_n;

        if (proc_take || ctrl_take) begin
            op = chip_on ? OP_LOAD : OP_DESEL;
        end else begin
            op = OP_CONT;
        end
        proc_load = proc_take && chip_on;

        if (!gw_n) begin
            raw_mask = '1;
        end else if (!bwe_n) begin
            raw_mask = ~bw_n;
        end else begin
            raw_mask = '0;
        end
        // processor-started edges are reads whatever the write pins say
        wr_mask = proc_take ? '0 : raw_mask;
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int ADDR_W = 4,
    parameter int BYTE_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  sbs_pkg::sbs_op_e  op,
    input  logic              proc_load,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [BYTE_N-1:0] wr_mask,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_N-1:0] acc_we,
    output logic              burst_active
);
    import sbs_pkg::*;

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } seq_t;

    seq_t       st_d, st_q;
    logic [1:0] step_d;

    always_comb begin
        st_d      = st_q;
        acc_valid = 1'b0;
        acc_addr  = st_q.base;
        step_d    = adv_n ? st_q.cnt : st_q.cnt + 2'd1;
        unique case (op)
            OP_LOAD: begin
                st_d.active = 1'b1;
                st_d.base   = ext_addr;
                st_d.cnt    = 2'd0;
                acc_valid   = 1'b1;
                acc_addr    = ext_addr;
            end
            OP_DESEL: begin
                st_d.active = 1'b0;
            end
            default: begin
                if (st_q.active) begin
                    st_d.cnt  = step_d;
                    acc_valid = 1'b1;
                    acc_addr  = {st_q.base[ADDR_W-1 -: HI_W],
                                 burst_lsb(st_q.base[1:0], step_d, order_il)};
                end
            end
        endcase
        acc_we = acc_valid ? wr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign burst_active = st_q.active;

    // R3: a processor-started burst never writes on its load edge
    p_proc_load_reads_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD && proc_load) |-> (acc_we == '0));

    // R9: a deselect edge leaves no burst running
    p_deselect_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DESEL) |=> !burst_active);

    // R10: no access while idle and no strobe taken
    p_idle_no_access_r10: assert property (@(posedge clk) disable iff (rst)
        (!burst_active && op == OP_CONT) |-> !acc_valid);

endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
    parameter int ADDR_W = 4,
    parameter int BYTE_N = 4
) (
    input  logic                  clk,
    input  logic [BYTE_N-1:0]     we,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic [8*BYTE_N-1:0]   wdata,
    input  logic [ADDR_W-1:0]     raddr,
    output logic [8*BYTE_N-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < BYTE_N; b++) begin : g_lane
        logic [7:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we[b]) begin
                lane[waddr] <= wdata[8*b +: 8];
            end
        end

        assign rdata[8*b +: 8] = lane[raddr];
    end

endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
    parameter int ADDR_W = 4,
    parameter int BYTE_N = 4
) (
    input  logic                 clk,
    input  logic                rst,
    input  logic                ads_proc_n,
    input  logic                ads_ctrl_n,
    input  logic                adv_n,
    input  logic                sel_main_n,
    input  logic                sel_pos,
    input  logic                sel_neg_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [BYTE_N-1:0]   bw_n,
    input  logic                oe_n,
    input  logic                order_il,
    input  logic                pipe_mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [8*BYTE_N-1:0] wdata,
    output logic [8*BYTE_N-1:0] rdata,
    output logic                rdata_en
);
    import sbs_pkg::*;

    localparam int DATA_W = 8 * BYTE_N;

    typedef struct packed {
        logic              v1;
        logic [ADDR_W-1:0] a1;
        logic              v2;
        logic [DATA_W-1:0] d2;
    } pipe_t;

    sbs_op_e           op;
    logic              proc_load;
    logic [BYTE_N-1:0] wr_mask;
    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_N-1:0] acc_we;
    logic              burst_active;
    logic [DATA_W-1:0] arr_rdata;
    logic              out_v;
    logic [DATA_W-1:0] out_data;
    logic              wr_edge;

    pipe_t st_d, st_q;

    sbs_decode #(.BYTE_N(BYTE_N)) u_decode (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .sel_main_n (sel_main_n),
        .sel_pos    (sel_pos),
        .sel_neg_n  (sel_neg_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .op         (op),
        .proc_load  (proc_load),
        .wr_mask    (wr_mask)
    );

    sbs_burst_seq #(.ADDR_W(ADDR_W), .BYTE_N(BYTE_N)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .proc_load    (proc_load),
        .adv_n        (adv_n),
        .order_il     (order_il),
        .ext_addr     (addr),
        .wr_mask      (wr_mask),
        .acc_valid    (acc_valid),
        .acc_addr     (acc_addr),
        .acc_we       (acc_we),
        .burst_active (burst_active)
    );

    sbs_store #(.ADDR_W(ADDR_W), .BYTE_N(BYTE_N)) u_store (
        .clk   (clk),
        .we    (acc_we),
        .waddr (acc_addr),
        .wdata (wdata),
        .raddr (st_q.a1),
        .rdata (arr_rdata)
    );

    always_comb begin
        wr_edge = |acc_we;
        st_d    = st_q;
        // stage 1: address register of the current access
        st_d.v1 = acc_valid && !wr_edge;
        if (acc_valid) begin
            st_d.a1 = acc_addr;
        end
        // stage 2: output register, muted by a write edge
        st_d.v2 = st_q.v1 && !wr_edge;
        st_d.d2 = arr_rdata;

        out_v    = pipe_mode ? st_q.v2 : st_q.v1;
        out_data = pipe_mode ? st_q.d2 : arr_rdata;
        rdata_en = out_v && !oe_n;
        rdata    = rdata_en ? out_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a write edge leaves the output undriven
    p_write_mutes_r8: assert property (@(posedge clk) disable iff (rst)
        (|acc_we) |=> !rdata_en);

    // R2: controller strobe with global write and full enables writes all bytes
    p_ctrl_write_all_r2: assert property (@(posedge clk) disable iff (rst)
        (!ads_ctrl_n && ads_proc_n && !sel_main_n && sel_pos && !sel_neg_n && !gw_n)
        |-> (&acc_we));

    // R4: a suspend edge repeats the previous address
    p_suspend_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (burst_active && op == OP_CONT && adv_n) |=> $stable(st_q.a1));

endmodule

// File: tb/test_sbs_sram.sv
module test_sbs_sram;

    logic        clk = 1'b0;
    logic        rst;
    logic        ads_proc_n, ads_ctrl_n, adv_n;
    logic        sel_main_n, sel_pos, sel_neg_n;
    logic        gw_n, bwe_n, oe_n, order_il, pipe_mode;
    logic [3:0]  bw_n;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rdata_en;

    int    vectors = 0;
    int    misses  = 0;
    string cur_req = "R11";

    // behavioural reference state
    logic [31:0] ref_mem [16];
    int          m_act = 0, m_base = 0, m_cnt = 0;
    int          m_v1 = 0, m_a1 = 0, m_v2 = 0;
    logic [31:0] m_d2 = '0;

    always #10 clk = ~clk;

    sbs_sram i_sbs_sram (
        .clk        (clk),
        .rst        (rst),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .sel_main_n (sel_main_n),
        .sel_pos    (sel_pos),
        .sel_neg_n  (sel_neg_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .oe_n       (oe_n),
        .order_il   (order_il),
        .pipe_mode  (pipe_mode),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rdata_en   (rdata_en)
    );

    task automatic model_edge();
        int mask, acc, aaddr, lo;
        bit proc, ctrl, chip;
        if (rst) begin
            m_act = 0; m_v1 = 0; m_v2 = 0; m_cnt = 0;
            return;
        end
        proc = !ads_proc_n && !sel_main_n;
        ctrl = !ads_ctrl_n && (ads_proc_n || sel_main_n);
        chip = !sel_main_n && sel_pos && !sel_neg_n;
        if (!gw_n) mask = 15;
        else if (!bwe_n) mask = int'(~bw_n) & 15;
        else mask = 0;
        if (proc) mask = 0;
        acc = 0;
        aaddr = 0;
        if (proc || ctrl) begin
            if (chip) begin
                m_act = 1; m_base = int'(addr); m_cnt = 0;
                acc = 1; aaddr = int'(addr);
            end else begin
                m_act = 0;
            end
        end else if (m_act != 0) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            lo = order_il ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
            aaddr = (m_base / 4) * 4 + lo;
            acc = 1;
        end
        if (acc == 0) mask = 0;
        m_d2 = ref_mem[m_a1];
        m_v2 = (m_v1 != 0 && mask == 0) ? 1 : 0;
        if (acc != 0) begin
            for (int b = 0; b < 4; b++) begin
                if (mask[b]) ref_mem[aaddr][8*b +: 8] = wdata[8*b +: 8];
            end
            m_a1 = aaddr;
        end
        m_v1 = (acc != 0 && mask == 0) ? 1 : 0;
    endtask

    task automatic compare();
        int          v;
        logic        e_en;
        logic [31:0] e_d;
        v    = pipe_mode ? m_v2 : m_v1;
        e_en = (v != 0) && !oe_n;
        e_d  = e_en ? (pipe_mode ? m_d2 : ref_mem[m_a1]) : 32'h0;
        vectors++;
        if (rdata_en !== e_en || rdata !== e_d) begin
            misses++;
            $display("FAIL %s: rdata_en/rdata = %0b/%h, expected %0b/%h",
                     cur_req, rdata_en, rdata, e_en, e_d);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_in();
        ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1;
        sel_main_n = 0; sel_pos = 1; sel_neg_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0;
        addr = '0; wdata = '0;
    endtask

    task automatic proc_load(input int a);
        idle_in(); ads_proc_n = 0; addr = 4'(a); tick();
    endtask

    task automatic ctrl_write(input int a, input logic [31:0] d);
        idle_in(); ads_ctrl_n = 0; addr = 4'(a); gw_n = 0; wdata = d; tick();
    endtask

    task automatic step_read(input bit go);
        idle_in(); adv_n = !go; tick();
    endtask

    task automatic step_write(input bit go, input bit glob, input logic [3:0] sel,
                              input logic [31:0] d);
        idle_in(); adv_n = !go; wdata = d;
        if (glob) gw_n = 0;
        else begin bwe_n = 0; bw_n = sel; end
        tick();
    endtask

    task automatic read_burst(input int a);
        proc_load(a);
        for (int k = 0; k < 3; k++) step_read(1);
        step_read(1);
        idle_in(); ads_ctrl_n = 0; sel_pos = 0; tick();
        idle_in(); tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL R11 watchdog: run still active, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : stimulus
        for (int i = 0; i < 16; i++) ref_mem[i] = '0;
        idle_in();
        order_il = 1; pipe_mode = 1; rst = 1;
        @(negedge clk);
        cur_req = "R11";
        tick(); tick();
        rst = 0;
        tick();

        // fill the array in four bursts
        cur_req = "R2";
        for (int blk = 0; blk < 4; blk++) begin
            ctrl_write(blk * 4, 32'hC0DE0000 + 32'(blk * 16));
            for (int k = 1; k < 4; k++) step_write(1, 1, 4'hF, 32'h5A000000 + 32'(blk * 256 + k * 17));
        end
        idle_in(); tick();

        cur_req = "R5 R7";
        read_burst(6);
        read_burst(13);

        cur_req = "R4";
        proc_load(9); step_read(0); step_read(0); step_read(1); step_read(0); step_read(1);
        ctrl_write(3, 32'h11112222);
        step_write(0, 0, 4'b0110, 32'hAABBCCDD);
        step_write(1, 1, 4'hF, 32'h0F0F0F0F);
        read_burst(0);

        cur_req = "R6";
        idle_in(); ads_ctrl_n = 0; addr = 4'd5; bwe_n = 0; bw_n = 4'b1010; wdata = 32'h99887766; tick();
        step_write(1, 0, 4'hF, 32'hFFFFFFFF);
        idle_in(); adv_n = 0; bwe_n = 1; bw_n = 4'h0; wdata = 32'hEEEEEEEE; tick();
        step_write(1, 0, 4'b0111, 32'h12345678);
        read_burst(4);

        cur_req = "R3";
        idle_in(); ads_proc_n = 0; ads_ctrl_n = 0; gw_n = 0; addr = 4'd10; wdata = 32'hDEADBEEF; tick();
        step_read(1);
        read_burst(10);

        cur_req = "R1";
        idle_in(); sel_main_n = 1; ads_proc_n = 0; addr = 4'd2; tick();
        step_read(1);
        proc_load(14); step_read(1);
        idle_in(); sel_main_n = 1; ads_proc_n = 0; adv_n = 0; addr = 4'd1; tick();
        step_read(1); step_read(1);

        cur_req = "R9";
        proc_load(7);
        idle_in(); sel_main_n = 1; ads_ctrl_n = 0; tick();
        step_read(1);
        proc_load(8);
        idle_in(); ads_proc_n = 0; sel_neg_n = 1; tick();
        step_read(1);
        proc_load(12);
        idle_in(); ads_proc_n = 0; sel_pos = 0; tick();

        cur_req = "R10";
        step_write(1, 1, 4'hF, 32'hBAD0BAD0);
        step_write(0, 0, 4'h0, 32'hBAD1BAD1);
        step_read(1);
        read_burst(12);

        cur_req = "R8";
        proc_load(1); step_read(1);
        idle_in(); adv_n = 0; oe_n = 1; tick();
        idle_in(); oe_n = 1; tick();
        step_read(1);
        step_write(1, 0, 4'b1110, 32'h00000042);
        step_read(1); step_read(1);
        read_burst(0);

        cur_req = "R5";
        order_il = 0;
        idle_in(); tick();
        read_burst(1);
        read_burst(7);
        read_burst(14);
        ctrl_write(11, 32'h7777AAAA);
        for (int k = 0; k < 3; k++) step_write(1, 1, 4'hF, 32'h31000000 + 32'(k));
        read_burst(9);

        cur_req = "R7";
        pipe_mode = 0;
        idle_in(); tick();
        read_burst(2);
        order_il = 1;
        idle_in(); tick();
        read_burst(11);
        proc_load(6); step_read(0);
        step_write(1, 1, 4'hF, 32'h600DF00D);
        step_read(1);
        idle_in(); ads_ctrl_n = 0; sel_pos = 0; tick();
        read_burst(4);

        cur_req = "R11";
        proc_load(3);
        rst = 1; idle_in(); tick();
        rst = 0; tick();
        step_read(1); step_read(1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule